// File: doc/BRIEF.md
# Envelope Generator (Attack, Decay, Sustain, Release)

This block shapes a control envelope for one synthesizer voice. On every sample strobe it produces one unsigned Q0.16 sample between zero and full scale, together with the phase it is in. A gate-on event starts a rising attack segment. The envelope then falls through a decay segment to a held sustain level. A gate-off event starts a falling release segment that ends at rest. The rising and falling shapes come from two curve tables built inside the block. A phase accumulator steps through these tables, and the block interpolates linearly between neighbouring entries.

Each timed phase gets its own 24-bit phase increment. The block clamps each increment to a fixed legal window, and the conversion from seconds to increments happens outside the block. A retrigger or a release starts from the output value at that moment, so the envelope never jumps. The sample leaves on a source-timed stream: `sample_valid` is high for one cycle per strobe, and there is no back-pressure, so the consumer must take every sample. Strobes must be at least two clock cycles apart.

Top module: `adsr_envelope`

## Requirements
- R1: While `rst_n` is low and after its release, `env_state` is 0 (rest), `sample` is 0 and `sample_valid` is 0.
- R2: The `env_state` codes are: 0 rest, 1 attack, 2 decay, 3 sustain, 4 release. Attack, decay and release are the timed phases. On a strobe in a timed phase, the 24-bit accumulator adds that phase's increment. A carry out of bit 23 wraps the accumulator and moves attack to decay, decay to sustain, and release to rest. With an increment of 167772, the carry happens on the 101st advancing strobe.
- R3: Sustain and rest never change phase on their own. Only a gate event moves the block out of them.
- R4: A gate-on in any phase other than attack stores the current `sample` as the start level, clears the accumulator and enters attack. A gate-on in attack is ignored, and the accumulator keeps advancing.
- R5: A gate-off in attack, decay or sustain stores the current `sample` as the release level, clears the accumulator and enters release. A gate-off in release or rest is ignored.
- R6: A gate pulse is held until the next strobe, including a pulse in the same cycle as the strobe, and acts on that strobe. The strobe that acts on a gate does not advance the accumulator. If both gates are pending, gate-off is discarded and only the gate-on rule applies.
- R7: The per-phase outputs are built with the rounded product sc(a,b) = min((a*b + 32768) >> 16, 65535) and the curve value c, using FS = 65535. Attack gives start + sc(FS−start, c). Decay gives S + sc(FS−S, c). Sustain gives S. Release gives sc(release level, c). Rest gives 0. Every sum saturates at FS.
- R8: The table has 64 entries, i = 0..63. The falling table is f[i] = floor((65535·(63−i)² + 1984) / 3969). The rising table is 65535 − f[i]. Attack reads the rising table, and decay and release both read the falling table.
- R9: Accumulator bits 23:18 form the index i, and bits 17:10 form the weight w. The curve value is c = y0 + floor(((y1 − y0)·w + 128) / 256), where y0 = T[i] and y1 = T[min(i+1, 63)].
- R10: Sustain and rest never advance the accumulator. Every strobe, in any phase, recomputes the output.
- R11: Before use, each increment is clamped to the range 18 to 349525.
- R12: `sample` and `sample_valid` update on the second rising edge after the edge that samples `tick`. `sample_valid` is high for exactly one cycle, and `sample` holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample-rate strobe, one cycle wide |
| gate_on | input | 1 | Gate-on event pulse |
| gate_off | input | 1 | Gate-off event pulse |
| attack_inc | input | 24 | Attack phase increment per strobe |
| decay_inc | input | 24 | Decay phase increment per strobe |
| release_inc | input | 24 | Release phase increment per strobe |
| sustain_lvl | input | 16 | Sustain level, Q0.16 |
| sample | output | 16 | Envelope sample, Q0.16 |
| sample_valid | output | 1 | One-cycle marker of a new sample |
| env_state | output | 3 | Current phase code |

## Verification
A wrong phase register shows on `env_state` in the cycle after the strobe that caused it. It also reaches `sample` one cycle later, because the table and the formula change with the phase. A bad accumulator value or a bad clamp shows up as a drift of `sample` away from the curve within a few strobes, and as a phase change one strobe early or late. A bad captured start or release level shows as a step in the first sample of the new segment. Because every strobe is compared with an independent model, the first wrong sample is caught within one strobe.

// File: rtl/adsr_pkg.sv
package adsr_pkg;
  typedef enum logic [2:0] {
    ST_REST    = 3'd0,
    ST_ATTACK  = 3'd1,
    ST_DECAY   = 3'd2,
    ST_SUSTAIN = 3'd3,
    ST_RELEASE = 3'd4
  } env_state_e;
endpackage

// File: rtl/adsr_curve_rom.sv
module adsr_curve_rom #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LUT_AW = 6
) (
  input  logic              sel_rise,
  input  logic [LUT_AW-1:0] idx_a,
  input  logic [LUT_AW-1:0] idx_b,
  output logic [DATA_W-1:0] y_a,
  output logic [DATA_W-1:0] y_b
);
  localparam int unsigned TAB_LEN = 1 << LUT_AW;
  localparam longint unsigned FULL = (longint'(1) << DATA_W) - 1;

  // quadratic stand-in for an RC discharge, computed at elaboration
  function automatic logic [DATA_W-1:0] fall_pt(input int unsigned i);
    longint unsigned span;
    longint unsigned num;
    span = longint'(TAB_LEN - 1) * longint'(TAB_LEN - 1);
    num  = FULL * longint'(TAB_LEN - 1 - i) * longint'(TAB_LEN - 1 - i);
    return DATA_W'((num + span / 2) / span);
  endfunction

  logic [DATA_W-1:0] fall_tab [TAB_LEN];
  logic [DATA_W-1:0] rise_tab [TAB_LEN];

  for (genvar g = 0; g < TAB_LEN; g++) begin : g_tab
    assign fall_tab[g] = fall_pt(g);
    assign rise_tab[g] = DATA_W'(FULL) - fall_pt(g);
  end

  assign y_a = sel_rise ? rise_tab[idx_a] : fall_tab[idx_a];
  assign y_b = sel_rise ? rise_tab[idx_b] : fall_tab[idx_b];
endmodule

// File: rtl/adsr_phase_acc.sv
module adsr_phase_acc #(
  parameter int unsigned ACC_W   = 24,
  parameter int unsigned MIN_INC = 18,
  parameter int unsigned MAX_INC = 349525
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  input  logic [ACC_W-1:0] inc_raw,
  output logic [ACC_W-1:0] acc,
  output logic             carry
);
  localparam logic [ACC_W-1:0] INC_LO = ACC_W'(MIN_INC);
  localparam logic [ACC_W-1:0] INC_HI = ACC_W'(MAX_INC);

  logic [ACC_W-1:0] inc_c;
  logic [ACC_W:0]   sum;

  always_comb begin
    if (inc_raw < INC_LO)      inc_c = INC_LO;
    else if (inc_raw > INC_HI) inc_c = INC_HI;
    else                       inc_c = inc_raw;
    sum   = {1'b0, acc} + {1'b0, inc_c};
    carry = sum[ACC_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       acc <= '0;
    else if (clear)   acc <= '0;
    else if (advance) acc <= sum[ACC_W-1:0];
  end
endmodule

// File: rtl/adsr_ctrl.sv
module adsr_ctrl
  import adsr_pkg::*;
#(
  parameter int unsigned ACC_W  = 24,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              gate_on,
  input  logic              gate_off,
  input  logic [ACC_W-1:0]  attack_inc,
  input  logic [ACC_W-1:0]  decay_inc,
  input  logic [ACC_W-1:0]  release_inc,
  input  logic [DATA_W-1:0] cur_sample,
  input  logic [ACC_W-1:0]  acc,
  input  logic              carry,
  output env_state_e        state_q,
  output logic              acc_clear,
  output logic              acc_adv,
  output logic [ACC_W-1:0]  inc_sel,
  output logic [DATA_W-1:0] start_q,
  output logic [DATA_W-1:0] rel_q
);
  logic pend_on, pend_off;
  logic eff_on, eff_off;
  logic timed, gated_phase;
  logic go_attack, go_release;
  env_state_e state_d;

  always_comb begin
    eff_on      = pend_on | gate_on;
    eff_off     = pend_off | gate_off;
    timed       = (state_q == ST_ATTACK) || (state_q == ST_DECAY) || (state_q == ST_RELEASE);
    gated_phase = (state_q == ST_ATTACK) || (state_q == ST_DECAY) || (state_q == ST_SUSTAIN);
    go_attack   = tick && eff_on && (state_q != ST_ATTACK);
    go_release  = tick && !eff_on && eff_off && gated_phase;
    acc_clear   = go_attack || go_release;
    acc_adv     = tick && timed && !acc_clear;

    unique case (state_q)
      ST_ATTACK:  inc_sel = attack_inc;
      ST_DECAY:   inc_sel = decay_inc;
      default:    inc_sel = release_inc;
    endcase

    state_d = state_q;
    if (go_attack)       state_d = ST_ATTACK;
    else if (go_release) state_d = ST_RELEASE;
    else if (acc_adv && carry) begin
      unique case (state_q)
        ST_ATTACK:  state_d = ST_DECAY;
        ST_DECAY:   state_d = ST_SUSTAIN;
        ST_RELEASE: state_d = ST_REST;
        default:    state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_REST;
      pend_on  <= 1'b0;
      pend_off <= 1'b0;
      start_q  <= '0;
      rel_q    <= '0;
    end else begin
      state_q  <= state_d;
      pend_on  <= tick ? 1'b0 : eff_on;
      pend_off <= tick ? 1'b0 : eff_off;
      if (go_attack)  start_q <= cur_sample;
      if (go_release) rel_q   <= cur_sample;
    end
  end

  AST_SUSTAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SUSTAIN && !gate_on && !gate_off && !pend_on && !pend_off) |=> state_q == ST_SUSTAIN); // R3
  AST_ATTACK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ATTACK && $past(state_q) != ST_ATTACK) |-> (acc == '0 && start_q == $past(cur_sample))); // R4
  AST_RELEASE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RELEASE && $past(state_q) != ST_RELEASE) |-> (acc == '0 && rel_q == $past(cur_sample))); // R5
  AST_REST_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REST && !gate_on && !pend_on) |=> state_q == ST_REST); // R5
  AST_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(state_q)); // R6
endmodule

// File: rtl/adsr_shaper.sv
module adsr_shaper
  import adsr_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LUT_AW = 6,
  parameter int unsigned WGT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  env_state_e              state,
  input  logic [LUT_AW+WGT_W-1:0] phase_hi,
  input  logic [DATA_W-1:0]       start_lvl,
  input  logic [DATA_W-1:0]       rel_lvl,
  input  logic [DATA_W-1:0]       sustain,
  output logic [DATA_W-1:0]       sample_q,
  output logic                    valid_q
);
  localparam int unsigned PROD_W = DATA_W + WGT_W + 2;
  localparam int unsigned MUL_W  = 2 * DATA_W + 1;
  localparam logic [DATA_W-1:0] FS = '1;
  localparam int W_HALF = 1 << (WGT_W - 1);
  localparam longint D_HALF = longint'(1) << (DATA_W - 1);

  function automatic logic [DATA_W-1:0] scale(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    logic [MUL_W-1:0]  p;
    logic [DATA_W:0]   r;
    p = MUL_W'(a) * MUL_W'(b) + MUL_W'(D_HALF);
    r = p[MUL_W-1:DATA_W];
    return (r > {1'b0, FS}) ? FS : r[DATA_W-1:0];
  endfunction

  logic                     calc;
  logic [LUT_AW-1:0]        idx, nxt;
  logic [WGT_W-1:0]         wgt;
  logic [DATA_W-1:0]        y0, y1, curve;
  logic signed [PROD_W-1:0] diff, prod, step, cur_s;
  logic [DATA_W-1:0]        base, part;
  logic [DATA_W:0]          tot;
  logic [DATA_W-1:0]        value;

  assign idx = phase_hi[LUT_AW+WGT_W-1 -: LUT_AW];
  assign wgt = phase_hi[WGT_W-1:0];
  assign nxt = (idx == '1) ? idx : idx + 1'b1;

  adsr_curve_rom #(.DATA_W(DATA_W), .LUT_AW(LUT_AW)) u_rom (
    .sel_rise (state == ST_ATTACK),
    .idx_a    (idx),
    .idx_b    (nxt),
    .y_a      (y0),
    .y_b      (y1)
  );

  always_comb begin
    diff  = PROD_W'($signed({1'b0, y1})) - PROD_W'($signed({1'b0, y0}));
    prod  = diff * PROD_W'($signed({1'b0, wgt}));
    step  = (prod + PROD_W'(W_HALF)) >>> WGT_W;
    cur_s = PROD_W'($signed({1'b0, y0})) + step;
    curve = cur_s[DATA_W-1:0];

    unique case (state)
      ST_ATTACK:  begin base = start_lvl; part = scale(FS - start_lvl, curve); end
      ST_DECAY:   begin base = sustain;   part = scale(FS - sustain, curve);   end
      ST_SUSTAIN: begin base = sustain;   part = '0;                           end
      ST_RELEASE: begin base = '0;        part = scale(rel_lvl, curve);        end
      default:    begin base = '0;        part = '0;                           end
    endcase
    tot   = {1'b0, base} + {1'b0, part};
    value = tot[DATA_W] ? FS : tot[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      calc     <= 1'b0;
      valid_q  <= 1'b0;
      sample_q <= '0;
    end else begin
      calc    <= tick;
      valid_q <= calc;
      if (calc) sample_q <= value;
    end
  end

  AST_REST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (calc && state == ST_REST) |=> sample_q == '0); // R7
  AST_SUSTAIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (calc && state == ST_SUSTAIN) |=> sample_q == $past(sustain)); // R7
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q); // R12
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !calc |=> $stable(sample_q)); // R12
endmodule

// File: rtl/adsr_envelope.sv
module adsr_envelope
  import adsr_pkg::*;
#(
  parameter int unsigned ACC_W   = 24,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned LUT_AW  = 6,
  parameter int unsigned WGT_W   = 8,
  parameter int unsigned MIN_INC = 18,
  parameter int unsigned MAX_INC = 349525
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              gate_on,
  input  logic              gate_off,
  input  logic [ACC_W-1:0]  attack_inc,
  input  logic [ACC_W-1:0]  decay_inc,
  input  logic [ACC_W-1:0]  release_inc,
  input  logic [DATA_W-1:0] sustain_lvl,
  output logic [DATA_W-1:0] sample,
  output logic              sample_valid,
  output logic [2:0]        env_state
);
  localparam int unsigned HI_W = LUT_AW + WGT_W;

  env_state_e        state;
  logic              acc_clear, acc_adv, carry;
  logic [ACC_W-1:0]  acc, inc_sel;
  logic [DATA_W-1:0] start_lvl, rel_lvl;

  adsr_ctrl #(.ACC_W(ACC_W), .DATA_W(DATA_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .gate_on     (gate_on),
    .gate_off    (gate_off),
    .attack_inc  (attack_inc),
    .decay_inc   (decay_inc),
    .release_inc (release_inc),
    .cur_sample  (sample),
    .acc         (acc),
    .carry       (carry),
    .state_q     (state),
    .acc_clear   (acc_clear),
    .acc_adv     (acc_adv),
    .inc_sel     (inc_sel),
    .start_q     (start_lvl),
    .rel_q       (rel_lvl)
  );

  adsr_phase_acc #(.ACC_W(ACC_W), .MIN_INC(MIN_INC), .MAX_INC(MAX_INC)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (acc_clear),
    .advance (acc_adv),
    .inc_raw (inc_sel),
    .acc     (acc),
    .carry   (carry)
  );

  adsr_shaper #(.DATA_W(DATA_W), .LUT_AW(LUT_AW), .WGT_W(WGT_W)) u_shape (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .state     (state),
    .phase_hi  (acc[ACC_W-1 -: HI_W]),
    .start_lvl (start_lvl),
    .rel_lvl   (rel_lvl),
    .sustain   (sustain_lvl),
    .sample_q  (sample),
    .valid_q   (sample_valid)
  );

  assign env_state = state;

  AST_RESET_REST: assert property (@(posedge clk) !rst_n |=> (env_state == 3'd0 && sample == '0 && !sample_valid)); // R1
  AST_STATE_CODE: assert property (@(posedge clk) disable iff (!rst_n) env_state <= 3'd4); // R2
endmodule

// File: tb/adsr_envelope_bench.sv
module adsr_envelope_bench;
  typedef struct packed {
    logic        on;
    logic        off;
    logic [15:0] n;
    logic [23:0] ai;
    logic [23:0] di;
    logic [23:0] ri;
    logic [15:0] sus;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 16'd210, 24'd167772,   24'd167772, 24'd167772, 16'd32768}, // R2 R3 full climb to sustain
    '{1'b0, 1'b1, 16'd105, 24'd167772,   24'd167772, 24'd167772, 16'd32768}, // R5 R2 release to rest
    '{1'b0, 1'b1, 16'd4,   24'd167772,   24'd167772, 24'd167772, 16'd32768}, // R5 gate-off at rest ignored
    '{1'b1, 1'b0, 16'd60,  24'hFFFFFF,   24'd200000, 24'd200000, 16'd20000}, // R11 upper clamp
    '{1'b1, 1'b0, 16'd30,  24'd300000,   24'd200000, 24'd200000, 16'd20000}, // R4 retrigger from decay
    '{1'b1, 1'b0, 16'd20,  24'd300000,   24'd200000, 24'd200000, 16'd20000}, // R4 gate-on in attack ignored
    '{1'b0, 1'b1, 16'd40,  24'd300000,   24'd200000, 24'd100000, 16'd20000}, // R5 release from attack
    '{1'b1, 1'b0, 16'd800, 24'd50000,    24'd50000,  24'd50000,  16'd0},     // R7 R8 retrigger from release, zero sustain
    '{1'b1, 1'b0, 16'd100, 24'd50000,    24'd50000,  24'd50000,  16'd65535}, // R9 R10 from sustain, full sustain
    '{1'b0, 1'b1, 16'd100, 24'd50000,    24'd50000,  24'd1,      16'd65535}, // R11 lower clamp
    '{1'b1, 1'b1, 16'd20,  24'd120000,   24'd50000,  24'd50000,  16'd40000}  // R6 both gates, on wins
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        gate_on = 1'b0;
  logic        gate_off = 1'b0;
  logic [23:0] attack_inc = 24'd167772;
  logic [23:0] decay_inc = 24'd167772;
  logic [23:0] release_inc = 24'd167772;
  logic [15:0] sustain_lvl = 16'd32768;
  logic [15:0] sample;
  logic        sample_valid;
  logic [2:0]  env_state;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int     m_state, m_start, m_rel, m_sample;
  longint m_acc;
  bit     m_pon, m_poff;

  always #2 clk = ~clk;

  adsr_envelope u_adsr_envelope (
    .clk, .rst_n, .tick, .gate_on, .gate_off, .attack_inc, .decay_inc,
    .release_inc, .sustain_lvl, .sample, .sample_valid, .env_state
  );

  function automatic int fall(int i);
    longint num = 65535 * longint'((63 - i) * (63 - i));
    return int'((num + 1984) / 3969);
  endfunction

  function automatic int sc(longint a, longint b);
    longint r = (a * b + 32768) >> 16;
    return (r > 65535) ? 65535 : int'(r);
  endfunction

  function automatic int clampi(int v);
    return (v < 18) ? 18 : ((v > 349525) ? 349525 : v);
  endfunction

  function automatic int model_out();
    int idx, nx, w, y0, y1, d, c, s;
    idx = int'(m_acc >> 18);
    w   = int'((m_acc >> 10) & 255);
    nx  = (idx == 63) ? 63 : idx + 1;
    y0  = (m_state == 1) ? 65535 - fall(idx) : fall(idx);
    y1  = (m_state == 1) ? 65535 - fall(nx) : fall(nx);
    d   = (y1 - y0) * w + 128;
    c   = y0 + (d >>> 8);
    case (m_state)
      1: s = m_start + sc(65535 - m_start, c);
      2: s = int'(sustain_lvl) + sc(65535 - int'(sustain_lvl), c);
      3: s = int'(sustain_lvl);
      4: s = sc(m_rel, c);
      default: s = 0;
    endcase
    return (s > 65535) ? 65535 : s;
  endfunction

  task automatic model_step();
    longint s;
    int inc;
    if (m_pon && m_state != 1) begin
      m_start = m_sample; m_acc = 0; m_state = 1;
    end else if (!m_pon && m_poff && m_state >= 1 && m_state <= 3) begin
      m_rel = m_sample; m_acc = 0; m_state = 4;
    end else if (m_state == 1 || m_state == 2 || m_state == 4) begin
      inc = (m_state == 1) ? clampi(int'(attack_inc)) :
            (m_state == 2) ? clampi(int'(decay_inc)) : clampi(int'(release_inc));
      s = m_acc + inc;
      m_acc = s & 64'hFFFFFF;
      if (s >= 64'h1000000) m_state = (m_state == 1) ? 2 : (m_state == 2) ? 3 : 0;
    end
    m_pon = 0; m_poff = 0;
    m_sample = model_out();
  endtask

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; gate_on = 1'b0; gate_off = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 state in reset", int'(env_state), 0);
    check("R1 sample in reset", int'(sample), 0);
    rst_n = 1'b1;
    m_state = 0; m_acc = 0; m_start = 0; m_rel = 0; m_sample = 0; m_pon = 0; m_poff = 0;
    @(negedge clk);
    check("R1 state after reset", int'(env_state), 0);
    check("R1 sample after reset", int'(sample), 0);
    check("R1 valid after reset", int'(sample_valid), 0);
  endtask

  task automatic pulse(input logic on_p, input logic off_p);
    @(negedge clk);
    gate_on = on_p; gate_off = off_p;
    if (on_p) m_pon = 1;
    if (off_p) m_poff = 1;
    @(negedge clk);
    gate_on = 1'b0; gate_off = 1'b0;
  endtask

  task automatic do_tick(input logic on_now, input logic off_now);
    @(negedge clk);
    tick = 1'b1; gate_on = on_now; gate_off = off_now;
    if (on_now) m_pon = 1;
    if (off_now) m_poff = 1;
    @(negedge clk);
    tick = 1'b0; gate_on = 1'b0; gate_off = 1'b0;
    model_step();
    @(negedge clk);
    check("R12 valid on strobe", int'(sample_valid), 1);
    check("R2 state", int'(env_state), m_state);
    check("R7 sample", int'(sample), m_sample);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R12 watchdog: got hang expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();

    for (int v = 0; v < NV; v++) begin
      attack_inc = VECS[v].ai; decay_inc = VECS[v].di;
      release_inc = VECS[v].ri; sustain_lvl = VECS[v].sus;
      if (VECS[v].on || VECS[v].off) pulse(VECS[v].on, VECS[v].off);
      for (int t = 0; t < int'(VECS[v].n); t++) do_tick(1'b0, 1'b0);
    end

    // R1 R2 R9: known first decay sample after 101 advancing strobes
    do_reset();
    attack_inc = 24'd167772; decay_inc = 24'd167772;
    release_inc = 24'd167772; sustain_lvl = 16'd32768;
    pulse(1'b1, 1'b0);
    do_tick(1'b0, 1'b0);
    check("R4 attack entry sample", int'(sample), 0);
    for (int t = 0; t < 100; t++) do_tick(1'b0, 1'b0);
    check("R2 still attack after 100", int'(env_state), 1);
    do_tick(1'b0, 1'b0);
    check("R2 decay on 101st", int'(env_state), 2);
    check("R9 first decay sample", int'(sample), 64878);

    // R12: valid drops the cycle after
    @(negedge clk);
    check("R12 valid one cycle", int'(sample_valid), 0);

    // R6: gate-off in the same cycle as the strobe
    do_tick(1'b0, 1'b1);
    check("R6 same-cycle gate-off", int'(env_state), 4);

    // R10: output holds without strobes
    repeat (5) @(negedge clk);
    check("R10 hold between strobes", int'(sample), m_sample);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule